// File: doc/BRIEF.md
# Interrupt CPU Interface Acknowledge Unit

This unit sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending candidate: an interrupt ID, a priority value and, for software-generated interrupts, the number of the CPU that raised it. The unit compares the candidate against a software-programmed priority threshold and raises a single registered interrupt line to the processor when the interface is enabled, the candidate passes the threshold and the candidate is not already in service.

Software talks to the unit through four word registers. A read of the claim register returns the candidate's ID and moves that ID into the in-service state. If nothing is eligible, the read returns a spurious ID, so a handler loop can stop. A write to the completion register retires an in-service ID. The written value may be the raw claim word, including the source-CPU field of a software interrupt. The unit reports each claim and each completion to the distributor as a one-cycle pulse carrying the ID.

Top module: `cpuif_ack_top`

## Requirements
- R1: After reset the interrupt line is low, the control and threshold registers read 0, no ID is in service and no claim or completion pulse is issued.
- R2: With the interface enabled, the interrupt line is high one cycle after a valid candidate whose ID is below NUM_IDS, which is not in service and whose priority is numerically lower than the threshold. A priority equal to or above the threshold keeps the line low.
- R3: While bit 0 of the control register (word 0) is 0, the line stays low and claim reads return the spurious ID.
- R4: A read of the claim register (word 2) of an eligible candidate returns the ID in bits [9:0] on the cycle after the read. It pulses claim_valid with that ID, and the ID enters the in-service state.
- R5: For a software interrupt (ID 0 to 15), bits [12:10] of the claim word hold the requesting CPU number. For IDs of 16 and above, bits [31:10] are 0.
- R6: A claim read with no eligible candidate returns 1023 in bits [9:0] and 0 above. It gives no claim pulse and changes no in-service state. Eligibility is lost when the interface is disabled, when no candidate is valid, when the ID is in service or at least NUM_IDS, or when the priority fails the threshold.
- R7: The line goes low on the cycle after a claim read. It stays low while the distributor keeps offering the now in-service ID.
- R8: A write to the completion register (word 3) whose bits [9:0] name an in-service ID retires that ID and pulses done_valid with the ID on the next cycle. Bits [31:10] of the write are ignored, so a raw claim word is accepted.
- R9: A completion write naming an ID that is not in service is ignored: no done pulse is issued and the in-service state is unchanged.
- R10: The control register (bit 0) and the 8-bit threshold register (word 1) read back what was written, one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_src | input | 3 | Requesting CPU of a software interrupt |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word select: 0 control, 1 threshold, 2 claim, 3 completion |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt line to the processor |
| claim_valid | output | 1 | One-cycle pulse on a successful claim |
| claim_id | output | 10 | ID of the claimed interrupt |
| done_valid | output | 1 | One-cycle pulse on an accepted completion |
| done_id | output | 10 | ID of the retired interrupt |

## Verification
The threshold comparison is swept over all 256 priorities against thresholds of 0, 0x10, 0xF0 and 0xFF. This separates a strict-less-than compare from an off-by-one or inclusive compare, and it confirms that a zero threshold blocks everything. The claim and completion path is swept over every software interrupt ID with rotating source-CPU numbers, and over a span of regular IDs up to the last legal one. This separates correct placement of the source field from its leakage into regular IDs. Each claim is followed by a repeated claim, which must be spurious, a completion with the raw word, and a repeated completion, which must be ignored. Together these tell in-service tracking apart from a design that simply echoes the candidate. Disabled-interface and out-of-range-ID cases show the spurious path is taken for each cause of ineligibility.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ID_W     = 10;
  localparam int SRC_W    = 3;
  localparam int PRIO_W   = 8;
  localparam int DATA_W   = 32;
  localparam int SRC_LSB  = 10;
  localparam int SGI_CNT  = 16;
  localparam int ID_SPACE = 1 << ID_W;

  localparam logic [ID_W-1:0] SPURIOUS_ID = '1;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_CLAIM = 2'd2,
    REG_DONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cpuif_regs.sv
module cpuif_regs
  import cpuif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic [PRIO_W-1:0] pmask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      pmask_q <= '0;
    end else if (wr) begin
      if (addr == REG_CTRL)  en_q    <= wdata[0];
      if (addr == REG_PMASK) pmask_q <= wdata[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active
  import cpuif_pkg::*;
#(
  parameter int NUM_IDS = 511
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_en,
  input  logic [ID_W-1:0]     set_id,
  input  logic                clr_en,
  input  logic [ID_W-1:0]     clr_id,
  output logic [ID_SPACE-1:0] act_q
);
  // Bits at or above NUM_IDS are never set; the full ID space keeps indexing width-clean.
  for (genvar i = 0; i < ID_SPACE; i++) begin : g_bit
    if (i < NUM_IDS) begin : g_live
      always_ff @(posedge clk) begin
        if (rst)
          act_q[i] <= 1'b0;
        else if (set_en && set_id == ID_W'(i))
          act_q[i] <= 1'b1;
        else if (clr_en && clr_id == ID_W'(i))
          act_q[i] <= 1'b0;
      end
    end else begin : g_dead
      assign act_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cpuif_gate.sv
module cpuif_gate
  import cpuif_pkg::*;
#(
  parameter int NUM_IDS = 511
) (
  input  logic              en,
  input  logic [PRIO_W-1:0] pmask,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [SRC_W-1:0]  cand_src,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              cand_busy,
  output logic              pass,
  output logic [DATA_W-1:0] claim_word
);
  localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(NUM_IDS);
  localparam logic [ID_W-1:0] SGI_LIM  = ID_W'(SGI_CNT);

  always_comb begin
    pass = en && cand_valid && !cand_busy &&
           (cand_id < ID_LIMIT) && (cand_prio < pmask);
    claim_word = '0;
    if (pass) begin
      claim_word[ID_W-1:0] = cand_id;
      if (cand_id < SGI_LIM)
        claim_word[SRC_LSB +: SRC_W] = cand_src;
    end else begin
      claim_word[ID_W-1:0] = SPURIOUS_ID;
    end
  end
endmodule

// File: rtl/cpuif_ack_top.sv
module cpuif_ack_top
  import cpuif_pkg::*;
#(
  parameter int NUM_IDS = 511
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [SRC_W-1:0]  cand_src,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic              claim_valid,
  output logic [ID_W-1:0]   claim_id,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id
);
  logic                en_q;
  logic [PRIO_W-1:0]   pmask_q;
  logic [ID_SPACE-1:0] act_q;
  logic                pass;
  logic [DATA_W-1:0]   claim_word;
  logic                claim_now;
  logic                done_now;
  logic [ID_W-1:0]     done_sel;

  cpuif_regs u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .en_q(en_q), .pmask_q(pmask_q)
  );

  cpuif_gate #(.NUM_IDS(NUM_IDS)) u_gate (
    .en(en_q), .pmask(pmask_q), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_src(cand_src), .cand_prio(cand_prio), .cand_busy(act_q[cand_id]),
    .pass(pass), .claim_word(claim_word)
  );

  assign claim_now = bus_rd && (bus_addr == REG_CLAIM) && pass;
  assign done_sel  = bus_wdata[ID_W-1:0];
  assign done_now  = bus_wr && (bus_addr == REG_DONE) && act_q[done_sel];

  cpuif_active #(.NUM_IDS(NUM_IDS)) u_act (
    .clk(clk), .rst(rst), .set_en(claim_now), .set_id(cand_id),
    .clr_en(done_now), .clr_id(done_sel), .act_q(act_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out     <= 1'b0;
      bus_rdata   <= '0;
      claim_valid <= 1'b0;
      claim_id    <= '0;
      done_valid  <= 1'b0;
      done_id     <= '0;
    end else begin
      irq_out     <= pass && !claim_now;
      claim_valid <= claim_now;
      done_valid  <= done_now;
      if (claim_now) claim_id <= cand_id;
      if (done_now)  done_id  <= done_sel;
      if (bus_rd) begin
        unique case (bus_addr)
          REG_CTRL:  bus_rdata <= DATA_W'(en_q);
          REG_PMASK: bus_rdata <= DATA_W'(pmask_q);
          REG_CLAIM: bus_rdata <= claim_word;
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cpuif_ack_chk.sv
module cpuif_ack_chk
  import cpuif_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                irq_out,
  input logic                en_q,
  input logic [PRIO_W-1:0]   pmask_q,
  input logic [PRIO_W-1:0]   cand_prio,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                claim_valid,
  input logic [ID_W-1:0]     claim_id,
  input logic                done_valid,
  input logic [ID_W-1:0]     done_id,
  input logic [ID_SPACE-1:0] act_q
);
  logic [ID_SPACE-1:0] act_d1;
  always_ff @(posedge clk) act_d1 <= rst ? '0 : act_q;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(en_q));                                   // R3
  AST_IRQ_BELOW_MASK: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(cand_prio < pmask_q));                    // R2
  AST_CLAIM_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    claim_valid |-> !irq_out);                                  // R7
  AST_CLAIM_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    claim_valid |-> act_q[claim_id]);                           // R4
  AST_CLAIM_RETURNS_ID: assert property (@(posedge clk) disable iff (rst)
    claim_valid |-> bus_rdata[ID_W-1:0] == claim_id);           // R4
  AST_DONE_WAS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> act_d1[done_id] && !act_q[done_id]);         // R9
endmodule

bind cpuif_ack_top cpuif_ack_chk u_chk (
  .clk(clk), .rst(rst), .irq_out(irq_out), .en_q(en_q), .pmask_q(pmask_q),
  .cand_prio(cand_prio), .bus_rdata(bus_rdata), .claim_valid(claim_valid),
  .claim_id(claim_id), .done_valid(done_valid), .done_id(done_id), .act_q(act_q)
);

// File: tb/sim_cpuif_ack_top.sv
module sim_cpuif_ack_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IDS    = 511;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [2:0]  cand_src = '0;
  logic [7:0]  cand_prio = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic        claim_valid;
  logic [9:0]  claim_id;
  logic        done_valid;
  logic [9:0]  done_id;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpuif_ack_top #(.NUM_IDS(NUM_IDS)) u0 (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_src(cand_src), .cand_prio(cand_prio), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .claim_valid(claim_valid), .claim_id(claim_id),
    .done_valid(done_valid), .done_id(done_id)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] claim_exp(input int id, input int src);
    return (id < 16) ? (32'(src) << 10) | 32'(id) : 32'(id);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] word;
    logic [7:0]  masks [4] = '{8'h00, 8'h10, 8'hF0, 8'hFF};
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check("R1 irq", 32'(irq_out), 0);
    check("R1 claim pulse", 32'(claim_valid), 0);
    check("R1 done pulse", 32'(done_valid), 0);
    rd(2'd0); check("R1 ctrl", bus_rdata, 0);
    rd(2'd1); check("R1 pmask", bus_rdata, 0);

    // R3: disabled interface with an urgent candidate
    wr(2'd1, 32'hF0);
    cand_valid = 1'b1; cand_id = 10'd50; cand_prio = 8'h00;
    tick(); tick();
    check("R3 irq low while disabled", 32'(irq_out), 0);
    rd(2'd2);
    check("R3 spurious while disabled", bus_rdata, 32'd1023);
    check("R3 no claim while disabled", 32'(claim_valid), 0);

    // R10: readback
    wr(2'd0, 32'h1);
    rd(2'd0); check("R10 ctrl readback", bus_rdata, 32'h1);
    rd(2'd1); check("R10 pmask readback", bus_rdata, 32'hF0);

    // R2: exhaustive priority against several thresholds
    foreach (masks[m]) begin
      wr(2'd1, 32'(masks[m]));
      for (int p = 0; p < 256; p++) begin
        cand_prio = 8'(p);
        tick();
        check("R2 threshold compare", 32'(irq_out), 32'(p < int'(masks[m])));
      end
    end
    wr(2'd1, 32'hF0);
    cand_prio = 8'h40;

    // R6: no valid candidate, and an out-of-range ID
    cand_valid = 1'b0; tick();
    check("R6 no candidate irq", 32'(irq_out), 0);
    rd(2'd2); check("R6 spurious no candidate", bus_rdata, 32'd1023);
    check("R6 no claim pulse", 32'(claim_valid), 0);
    cand_valid = 1'b1; cand_id = 10'(NUM_IDS); tick();
    check("R6 out-of-range irq", 32'(irq_out), 0);
    rd(2'd2); check("R6 spurious out-of-range", bus_rdata, 32'd1023);

    // R4 R5 R7 R8 R9: claim/complete sweep
    for (int id = 0; id < NUM_IDS; id = (id < 40) ? id + 1 : id + 47) begin
      int src;
      src = id % 8;
      cand_valid = 1'b1; cand_id = 10'(id); cand_src = 3'(src);
      tick();
      check("R2 irq on eligible", 32'(irq_out), 1);
      rd(2'd2);
      word = bus_rdata;
      check("R4 R5 claim word", word, claim_exp(id, src));
      check("R4 claim pulse", 32'(claim_valid), 1);
      check("R4 claim id", 32'(claim_id), 32'(id));
      check("R7 irq drops after claim", 32'(irq_out), 0);
      tick();
      check("R7 irq stays low", 32'(irq_out), 0);
      rd(2'd2);
      check("R6 reclaim spurious", bus_rdata, 32'd1023);
      check("R6 reclaim no pulse", 32'(claim_valid), 0);
      // raw word, with a junk bit set high above the source field
      wr(2'd3, word | 32'h8000_0000);
      check("R8 done pulse", 32'(done_valid), 1);
      check("R8 done id", 32'(done_id), 32'(id));
      wr(2'd3, word);
      check("R9 repeated done ignored", 32'(done_valid), 0);
      tick();
      check("R8 retired id eligible again", 32'(irq_out), 1);
    end
    // NUM_IDS-1 is the last legal ID
    cand_id = 10'(NUM_IDS - 1); cand_src = 3'd5; tick();
    rd(2'd2);
    check("R5 last id no src", bus_rdata, 32'(NUM_IDS - 1));
    wr(2'd3, bus_rdata);
    check("R8 last id done", 32'(done_valid), 1);

    // R9: completion of an idle ID leaves in-service state unchanged
    cand_id = 10'd70; tick();
    rd(2'd2);
    check("R4 claim 70", bus_rdata, 32'd70);
    wr(2'd3, 32'd71);
    check("R9 idle id ignored", 32'(done_valid), 0);
    tick();
    check("R9 70 still in service", 32'(irq_out), 0);
    wr(2'd3, 32'd70);
    check("R8 done 70", 32'(done_valid), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule